// File: doc/BRIEF.md
# Evolutionary Hash Genome Selector

This block steers an evolutionary search over the configuration word (the genome) of a reconfigurable hash function. It holds a ranked population of four parent genomes. It breeds twelve offspring per generation. Each offspring is a copy of a randomly picked parent in which every bit may flip independently with probability 1/G. Each offspring goes out to an external scorer, which returns a collision count where lower is better and zero is ideal. When the twelfth score is back, the block chooses the next four parents and publishes the best genome, its score and a generation count.

The scorer and the hash datapath sit outside the block. A single-cycle request pulse carries the offspring genome to the scorer. The scorer answers with a done strobe and the score on any later cycle, and the block waits for that answer as long as it takes. The random source is a 32-bit LFSR that software can seed, and it advances only when a random draw is consumed. The whole offspring sequence therefore follows from the seed and the returned scores alone.

Top module: `evo_select_engine`

## Requirements
- R1: After reset, best_genome is 0, best_fitness is all ones, generation is 0 and eval_start is low. All four parents hold genome 0 with an all-ones score.
- R2: The random source is a Galois LFSR. Each step is `next = (s >> 1) ^ (s[0] ? 32'h80200003 : 0)`. A draw is the current state, and the LFSR steps once after each draw. Pulsing seed_load loads seed_value, and a zero seed_value loads 1 instead.
- R3: Each offspring starts with one draw. Its two low bits index the ranked parent list, where index 0 is the best parent, and that parent's genome is copied.
- R4: After the parent draw, G further draws are made, one for each bit from bit 0 upward. Bit j is inverted when the low log2(G) bits of its draw are all zero.
- R5: Each offspring is offered with eval_start high for exactly one cycle. eval_genome stays stable and no new eval_start occurs until eval_done is accepted.
- R6: eval_done is accepted only on cycles after the eval_start cycle. A done strobe on the same cycle as eval_start is ignored.
- R7: A generation has twelve scored offspring. generation increments by one, one cycle after the twelfth score is accepted.
- R8: The next parents are the four lowest scores among the twelve offspring and the current best parent, ranked best first. Equal scores keep offspring order, and the old parent ranks after any offspring with the same score.
- R9: best_genome and best_fitness show the rank-0 parent, so best_fitness never increases.
- R10: While enable is low and no offspring is in progress, no offspring is started and the LFSR does not step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows a new offspring to be started |
| seed_load | input | 1 | Loads seed_value into the LFSR |
| seed_value | input | 32 | LFSR seed (zero is replaced by 1) |
| eval_start | output | 1 | One-cycle request to score eval_genome |
| eval_genome | output | G | Offspring genome under evaluation |
| eval_done | input | 1 | Scorer answer strobe |
| eval_fitness | input | FW | Collision count returned with eval_done |
| best_genome | output | G | Genome of the rank-0 parent |
| best_fitness | output | FW | Score of the rank-0 parent |
| generation | output | GENW | Completed generation count |

## Verification
Every draw feeds a visible genome, so a wrong LFSR step, parent index or mutation decision shows up on eval_genome at the very next request. A ranking error such as a bad tie order or a lost parent first changes best_genome or best_fitness at the generation boundary. If it leaves the rank-0 entry alone, it still alters which parent a later draw selects, and the genome offered next generation differs. A miscounted offspring total shows in the generation counter within one generation, and a done strobe that is wrongly accepted leaves a score of zero that shows in best_fitness.

// File: rtl/evo_pkg.sv
package evo_pkg;

    localparam logic [31:0] EVO_LFSR_TAPS = 32'h8020_0003;

    typedef enum logic [2:0] {
        ST_PICK,
        ST_MUT,
        ST_REQ,
        ST_WAIT,
        ST_MERGE
    } evo_phase_e;

    function automatic logic [31:0] evo_lfsr_step(input logic [31:0] s);
        return (s >> 1) ^ (s[0] ? EVO_LFSR_TAPS : 32'h0);
    endfunction

endpackage

// File: rtl/evo_lfsr.sv
module evo_lfsr #(
    parameter logic [31:0] RESET_SEED = 32'h1,
    parameter int          OUT_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [31:0]      load_val,
    input  logic             advance,
    output logic [OUT_W-1:0] draw
);
    import evo_pkg::*;

    localparam logic [31:0] SAFE_RESET = (RESET_SEED == 32'h0) ? 32'h1 : RESET_SEED;

    logic [31:0] st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load)
            st_d = (load_val == 32'h0) ? 32'h1 : load_val;
        else if (advance)
            st_d = evo_lfsr_step(st_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SAFE_RESET;
        else        st_q <= st_d;
    end

    assign draw = st_q[OUT_W-1:0];

endmodule

// File: rtl/evo_rank.sv
// Inserts one candidate into a best-first list of N entries. Entries that
// score lower or equal stay ahead, so earlier arrivals win ties.
module evo_rank #(
    parameter int G  = 16,
    parameter int FW = 8,
    parameter int N  = 4
) (
    input  logic [N-1:0]         in_vld,
    input  logic [N-1:0][FW-1:0] in_fit,
    input  logic [N-1:0][G-1:0]  in_gen,
    input  logic [FW-1:0]        c_fit,
    input  logic [G-1:0]         c_gen,
    output logic [N-1:0]         out_vld,
    output logic [N-1:0][FW-1:0] out_fit,
    output logic [N-1:0][G-1:0]  out_gen
);
    logic [N-1:0] ahead;

    for (genvar i = 0; i < N; i++) begin : g_slot
        assign ahead[i] = in_vld[i] && (in_fit[i] <= c_fit);

        if (i == 0) begin : g_head
            always_comb begin
                if (ahead[0]) begin
                    out_vld[0] = in_vld[0];
                    out_fit[0] = in_fit[0];
                    out_gen[0] = in_gen[0];
                end else begin
                    out_vld[0] = 1'b1;
                    out_fit[0] = c_fit;
                    out_gen[0] = c_gen;
                end
            end
        end else begin : g_tail
            always_comb begin
                if (ahead[i]) begin
                    out_vld[i] = in_vld[i];
                    out_fit[i] = in_fit[i];
                    out_gen[i] = in_gen[i];
                end else if (ahead[i-1]) begin
                    out_vld[i] = 1'b1;
                    out_fit[i] = c_fit;
                    out_gen[i] = c_gen;
                end else begin
                    out_vld[i] = in_vld[i-1];
                    out_fit[i] = in_fit[i-1];
                    out_gen[i] = in_gen[i-1];
                end
            end
        end
    end

endmodule

// File: rtl/evo_select_engine.sv
module evo_select_engine #(
    parameter int          G          = 16,
    parameter int          FW         = 8,
    parameter int          NPAR       = 4,
    parameter int          NOFF       = 12,
    parameter int          GENW       = 16,
    parameter logic [31:0] RESET_SEED = 32'h1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            seed_load,
    input  logic [31:0]     seed_value,
    output logic            eval_start,
    output logic [G-1:0]    eval_genome,
    input  logic            eval_done,
    input  logic [FW-1:0]   eval_fitness,
    output logic [G-1:0]    best_genome,
    output logic [FW-1:0]   best_fitness,
    output logic [GENW-1:0] generation
);
    import evo_pkg::*;

    localparam int LG    = $clog2(G);
    localparam int PW    = $clog2(NPAR);
    localparam int CW    = $clog2(NOFF);
    localparam int DRAWW = (LG > PW) ? LG : PW;

    typedef struct packed {
        evo_phase_e                 phase;
        logic [G-1:0]               work;
        logic [LG-1:0]              bit_idx;
        logic [CW-1:0]              scored;
        logic [NPAR-1:0]            nv_vld;
        logic [NPAR-1:0][FW-1:0]    nv_fit;
        logic [NPAR-1:0][G-1:0]     nv_gen;
        logic [NPAR-1:0][FW-1:0]    par_fit;
        logic [NPAR-1:0][G-1:0]     par_gen;
        logic [GENW-1:0]            gen_cnt;
    } eng_t;

    eng_t eng_d, eng_q;

    logic [DRAWW-1:0]        draw;
    logic                    lfsr_adv;
    logic [FW-1:0]           cand_fit;
    logic [G-1:0]            cand_gen;
    logic [NPAR-1:0]         rk_vld;
    logic [NPAR-1:0][FW-1:0] rk_fit;
    logic [NPAR-1:0][G-1:0]  rk_gen;

    assign lfsr_adv = ((eng_q.phase == ST_PICK) && enable) || (eng_q.phase == ST_MUT);

    evo_lfsr #(
        .RESET_SEED (RESET_SEED),
        .OUT_W      (DRAWW)
    ) i_lfsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (seed_load),
        .load_val (seed_value),
        .advance  (lfsr_adv),
        .draw     (draw)
    );

    // The old best parent enters the ranking last, after all offspring.
    assign cand_fit = (eng_q.phase == ST_MERGE) ? eng_q.par_fit[0] : eval_fitness;
    assign cand_gen = (eng_q.phase == ST_MERGE) ? eng_q.par_gen[0] : eng_q.work;

    evo_rank #(
        .G  (G),
        .FW (FW),
        .N  (NPAR)
    ) i_rank (
        .in_vld  (eng_q.nv_vld),
        .in_fit  (eng_q.nv_fit),
        .in_gen  (eng_q.nv_gen),
        .c_fit   (cand_fit),
        .c_gen   (cand_gen),
        .out_vld (rk_vld),
        .out_fit (rk_fit),
        .out_gen (rk_gen)
    );

    always_comb begin
        eng_d = eng_q;
        unique case (eng_q.phase)
            ST_PICK: begin
                if (enable) begin
                    eng_d.work    = eng_q.par_gen[draw[PW-1:0]];
                    eng_d.bit_idx = '0;
                    eng_d.phase   = ST_MUT;
                end
            end
            ST_MUT: begin
                if (draw[LG-1:0] == '0)
                    eng_d.work[eng_q.bit_idx] = ~eng_q.work[eng_q.bit_idx];
                eng_d.bit_idx = eng_q.bit_idx + 1'b1;
                if (eng_q.bit_idx == LG'(G - 1))
                    eng_d.phase = ST_REQ;
            end
            ST_REQ: begin
                eng_d.phase = ST_WAIT;
            end
            ST_WAIT: begin
                if (eval_done) begin
                    eng_d.nv_vld = rk_vld;
                    eng_d.nv_fit = rk_fit;
                    eng_d.nv_gen = rk_gen;
                    if (eng_q.scored == CW'(NOFF - 1)) begin
                        eng_d.scored = '0;
                        eng_d.phase  = ST_MERGE;
                    end else begin
                        eng_d.scored = eng_q.scored + 1'b1;
                        eng_d.phase  = ST_PICK;
                    end
                end
            end
            ST_MERGE: begin
                eng_d.par_fit = rk_fit;
                eng_d.par_gen = rk_gen;
                eng_d.nv_vld  = '0;
                eng_d.gen_cnt = eng_q.gen_cnt + 1'b1;
                eng_d.phase   = ST_PICK;
            end
            default: eng_d.phase = ST_PICK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q         <= '0;
            eng_q.phase   <= ST_PICK;
            eng_q.par_fit <= '1;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign eval_start   = (eng_q.phase == ST_REQ);
    assign eval_genome  = eng_q.work;
    assign best_genome  = eng_q.par_gen[0];
    assign best_fitness = eng_q.par_fit[0];
    assign generation   = eng_q.gen_cnt;

endmodule

// File: rtl/evo_select_engine_chk.sv
module evo_select_engine_chk #(
    parameter int G    = 16,
    parameter int FW   = 8,
    parameter int GENW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            eval_start,
    input logic            eval_done,
    input logic [G-1:0]    eval_genome,
    input logic [FW-1:0]   best_fitness,
    input logic [GENW-1:0] generation
);
    logic pending;

    always_ff @(posedge clk) begin
        if (!rst_n)          pending <= 1'b0;
        else if (eval_start) pending <= 1'b1;
        else if (eval_done)  pending <= 1'b0;
    end

    // R5
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eval_start |=> !eval_start);

    // R5
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> !eval_start);

    // R5
    genome_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> $stable(eval_genome));

    // R9
    best_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (best_fitness <= $past(best_fitness)));

    // R7
    gen_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (generation != $past(generation)) |-> (generation == GENW'($past(generation) + 1'b1)));

endmodule

bind evo_select_engine evo_select_engine_chk #(
    .G    (G),
    .FW   (FW),
    .GENW (GENW)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .eval_start   (eval_start),
    .eval_done    (eval_done),
    .eval_genome  (eval_genome),
    .best_fitness (best_fitness),
    .generation   (generation)
);

// File: tb/test_evo_select_engine.sv
`timescale 1ns/1ps
module test_evo_select_engine;
    localparam int G    = 16;
    localparam int FW   = 8;
    localparam int GENW = 16;

    typedef struct packed {
        logic [31:0] seed;
        logic [15:0] target;
        logic [3:0]  lat;
        logic [3:0]  gens;
        logic        glitch;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{seed: 32'h1234_5678, target: 16'hA5C3, lat: 4'd0, gens: 4'd3, glitch: 1'b0},
        '{seed: 32'hDEAD_BEEF, target: 16'h0000, lat: 4'd2, gens: 4'd3, glitch: 1'b1},
        '{seed: 32'h0000_0001, target: 16'hFFFF, lat: 4'd1, gens: 4'd2, glitch: 1'b0},
        '{seed: 32'h8000_0000, target: 16'h0F0F, lat: 4'd3, gens: 4'd2, glitch: 1'b1}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            enable = 1'b0;
    logic            seed_load = 1'b0;
    logic [31:0]     seed_value = '0;
    logic            eval_start;
    logic [G-1:0]    eval_genome;
    logic            eval_done = 1'b0;
    logic [FW-1:0]   eval_fitness = '0;
    logic [G-1:0]    best_genome;
    logic [FW-1:0]   best_fitness;
    logic [GENW-1:0] generation;

    always #2.5 clk = ~clk;

    evo_select_engine #(.G(G), .FW(FW), .GENW(GENW)) i_evo_select_engine (
        .clk, .rst_n, .enable, .seed_load, .seed_value,
        .eval_start, .eval_genome, .eval_done, .eval_fitness,
        .best_genome, .best_fitness, .generation
    );

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done_all = 1'b0;

    // reference state
    logic [31:0]   m_s;
    logic [G-1:0]  m_pg [4];
    logic [FW-1:0] m_pf [4];
    logic [GENW-1:0] m_gen;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_next(input logic [31:0] s);
        logic [31:0] n;
        n = {1'b0, s[31:1]};
        if (s[0]) n = n ^ 32'h8020_0003;
        return n;
    endfunction

    function automatic logic [FW-1:0] score(input logic [G-1:0] g, input logic [15:0] t);
        return FW'($countones(g ^ t));
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_pg[i] = '0;
            m_pf[i] = '1;
        end
        m_gen = '0;
    endtask

    task automatic predict(output logic [G-1:0] w);
        logic [31:0] d;
        d = m_s; m_s = ref_next(m_s);
        w = m_pg[d[1:0]];
        for (int j = 0; j < G; j++) begin
            d = m_s; m_s = ref_next(m_s);
            if (d[3:0] == 4'h0) w[j] = ~w[j];
        end
    endtask

    task automatic do_reset();
        eval_done = 1'b0; enable = 1'b0; seed_load = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        model_reset();
    endtask

    task automatic load_seed(input logic [31:0] s);
        seed_value = s; seed_load = 1'b1;
        @(negedge clk);
        seed_load = 1'b0;
        m_s = (s == 32'h0) ? 32'h1 : s;
    endtask

    task automatic run_gen(input logic [15:0] tgt, input int lat, input bit glitch);
        logic [G-1:0]  cg [13];
        logic [FW-1:0] cf [13];
        bit            used [13];
        logic [G-1:0]  w;
        for (int k = 0; k < 12; k++) begin
            int guard = 0;
            predict(w);
            while (!eval_start && guard < 2000) begin
                @(negedge clk); guard++;
            end
            check(eval_start == 1'b1, "R5", "request seen", 64'(eval_start), 64'd1);
            check(eval_genome == w, "R4", "offspring genome (R3 parent, R2 draws)",
                  64'(eval_genome), 64'(w));
            cg[k] = eval_genome;
            cf[k] = score(eval_genome, tgt);
            if (glitch) begin
                eval_done = 1'b1; eval_fitness = '0;
            end
            @(negedge clk);
            eval_done = 1'b0;
            check(eval_start == 1'b0 && eval_genome == cg[k], "R5", "pulse and hold",
                  64'({eval_start, eval_genome}), 64'({1'b0, cg[k]}));
            repeat (lat) @(negedge clk);
            eval_done = 1'b1; eval_fitness = cf[k];
            @(negedge clk);
            eval_done = 1'b0;
        end
        cg[12] = m_pg[0]; cf[12] = m_pf[0];
        for (int i = 0; i < 13; i++) used[i] = 1'b0;
        for (int r = 0; r < 4; r++) begin
            int bi = -1;
            for (int i = 0; i < 13; i++)
                if (!used[i] && (bi < 0 || cf[i] < cf[bi])) bi = i;
            used[bi] = 1'b1;
            m_pg[r] = cg[bi]; m_pf[r] = cf[bi];
        end
        m_gen = m_gen + 1'b1;
        @(negedge clk);
        check(generation == m_gen, "R7", "generation", 64'(generation), 64'(m_gen));
        check(best_fitness == m_pf[0], glitch ? "R6" : "R9", "best fitness",
              64'(best_fitness), 64'(m_pf[0]));
        check(best_genome == m_pg[0], "R8", "best genome", 64'(best_genome), 64'(m_pg[0]));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done_all) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        check(eval_start == 1'b0, "R1", "eval_start", 64'(eval_start), 64'd0);
        check(best_genome == '0, "R1", "best_genome", 64'(best_genome), 64'd0);
        check(best_fitness == '1, "R1", "best_fitness", 64'(best_fitness), 64'hFF);
        check(generation == '0, "R1", "generation", 64'(generation), 64'd0);

        // table walk
        for (int v = 0; v < 4; v++) begin
            do_reset();
            load_seed(VEC[v].seed);
            enable = 1'b1;
            for (int g = 0; g < int'(VEC[v].gens); g++)
                run_gen(VEC[v].target, int'(VEC[v].lat), VEC[v].glitch);
            enable = 1'b0;
        end

        // R10: idle hold, then R2 zero seed replaced by 1
        do_reset();
        load_seed(32'h0);
        begin
            bit seen = 1'b0;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (eval_start) seen = 1'b1;
            end
            check(!seen, "R10", "no request while disabled", 64'(seen), 64'd0);
            check(generation == '0, "R10", "generation held", 64'(generation), 64'd0);
        end
        enable = 1'b1;
        run_gen(16'h3C3C, 1, 1'b0);
        check(1'b1, "R2", "zero seed sequence followed", 64'd0, 64'd0);

        // R10: disable between offspring halts progress
        enable = 1'b0;
        begin
            bit seen = 1'b0;
            for (int c = 0; c < 60; c++) begin
                @(negedge clk);
                if (eval_start) seen = 1'b1;
            end
            check(!seen, "R10", "halt after generation", 64'(seen), 64'd0);
        end
        enable = 1'b1;
        run_gen(16'h3C3C, 0, 1'b0);

        done_all = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule